// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a virtual address into a physical address through two table levels. The top bits of the address pick an entry in a small segment table. That entry holds three things: a base index into a page-table memory, the segment's size in pages, and a write-enable flag. The middle bits give the page within the segment. The page is added to the base to pick a page-table entry, which holds a frame number, a write-enable flag and a valid bit. The low bits pass through untouched and are appended to the frame.

Each request carries an address and a read/write flag. The block checks, in this order:
- the page bound against the segment size,
- the segment's write permission,
- the page entry's validity,
- the page entry's write permission.

The first check that fails sets a three-bit fault code. If every check passes, the block returns the physical address. Requests and responses use valid/ready handshakes. The pipeline is two stages deep, so it accepts one request per cycle and returns each response two cycles after the request is accepted. A separate write port loads either table, one entry per cycle.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high. Every segment has size zero and every page entry is invalid, so any request answers with fault 1.
- R2: The virtual address splits into segment `[31:28]`, page `[27:12]` and offset `[11:0]`. On success, `rsp_fault` is 0 and `rsp_paddr` equals the 20-bit frame followed by the unchanged 12-bit offset.
- R3: A page number greater than or equal to the segment size gives fault 1 (bound).
- R4: A write through a segment whose write flag is 0 gives fault 2. Reads through such a segment are not refused by the segment.
- R5: A page entry whose valid bit is 0 gives fault 3.
- R6: A write to a valid page entry whose write flag is 0 gives fault 4.
- R7: When several checks fail, the reported code is the lowest of 1, 2, 3 and 4. No code other than 0 to 4 is ever produced.
- R8: Whenever `rsp_fault` is nonzero, `rsp_paddr` is zero.
- R9: Suppose a request is accepted in cycle c and `rsp_ready` is high in cycle c+1. Then its response is valid in cycle c+2. With `rsp_ready` held high, one request can be accepted every cycle.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and `req_ready` is low. Responses come out in request order.
- R11: A table write with `tbl_wr_page`=0 loads segment `tbl_wr_addr[3:0]` from `tbl_wr_data`: base in bits `[7:0]`, size in bits `[23:8]`, write flag in bit 24. A write with `tbl_wr_page`=1 loads page entry `tbl_wr_addr`: frame in bits `[19:0]`, write flag in bit 20, valid in bit 21. The page-entry index is (base + page) modulo 256. A write applies to requests accepted in later cycles; a request accepted in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 3 | 0 none, 1 bound, 2 segment read-only, 3 page invalid, 4 page read-only |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_page | input | 1 | 1 = page table, 0 = segment table |
| tbl_wr_addr | input | 8 | Entry index |
| tbl_wr_data | input | 25 | Entry contents |

## Verification
The assertions check four things on every cycle:
- a stalled response holds its value,
- only legal fault codes appear,
- an accepted request reaches the output two cycles later whenever the output is draining,
- a segment write is visible in the next cycle.

The bench's scenarios are the only way to show the rest. That covers the fault priority when several checks fail together, the wrap of the page-entry index past the end of the memory, and the read-before-write ordering of a table write against a request in the same cycle. It also covers the exact frame-and-offset result under random backpressure.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_BOUND   = 3'd1,
      FLT_SEG_RO  = 3'd2,
      FLT_PTE_INV = 3'd3,
      FLT_PTE_RO  = 3'd4
   } fault_e;

   // First failing check wins: bound, segment permission, entry validity, entry permission.
   function automatic fault_e pick_fault(input logic bound, input logic seg_ro,
                                         input logic pte_inv, input logic pte_ro);
      if (bound)        return FLT_BOUND;
      else if (seg_ro)  return FLT_SEG_RO;
      else if (pte_inv) return FLT_PTE_INV;
      else if (pte_ro)  return FLT_PTE_RO;
      else              return FLT_NONE;
   endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_W  = 4,
   parameter int PAGE_W = 16,
   parameter int PT_AW  = 8,
   localparam int N_SEG = 1 << SEG_W,
   localparam int ENT_W = PT_AW + PAGE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [ENT_W-1:0]  wr_data,
   input  logic [SEG_W-1:0]  rd_idx,
   output logic [PT_AW-1:0]  rd_base,
   output logic [PAGE_W-1:0] rd_len,
   output logic              rd_rw
);

   logic [ENT_W-1:0] ent [N_SEG];

   for (genvar g = 0; g < N_SEG; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[g] <= '0;
         else if (wr_en && wr_idx == SEG_W'(g))
            ent[g] <= wr_data;
      end
   end

   always_comb begin
      rd_base = ent[rd_idx][PT_AW-1:0];
      rd_len  = ent[rd_idx][PT_AW+PAGE_W-1:PT_AW];
      rd_rw   = ent[rd_idx][ENT_W-1];
   end

   // A segment loaded in one cycle is what the read port shows in the next.
   assert_seg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == rd_idx) ##1 (rd_idx == $past(wr_idx))
      |-> (rd_len == $past(wr_data[PT_AW+PAGE_W-1:PT_AW]) && rd_rw == $past(wr_data[ENT_W-1])));

endmodule

// File: rtl/page_mem.sv
module page_mem #(
   parameter int PT_AW   = 8,
   parameter int FRAME_W = 20,
   localparam int DEPTH  = 1 << PT_AW,
   localparam int ENT_W  = FRAME_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PT_AW-1:0]   wr_addr,
   input  logic [ENT_W-1:0]   wr_data,
   input  logic               rd_en,
   input  logic [PT_AW-1:0]   rd_addr,
   output logic [FRAME_W-1:0] rd_frame,
   output logic               rd_rw,
   output logic               rd_valid
);

   logic [FRAME_W:0] store [DEPTH];
   logic [DEPTH-1:0] vld;

   always_ff @(posedge clk) begin
      if (wr_en)
         store[wr_addr] <= wr_data[FRAME_W:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         vld <= '0;
      else if (wr_en)
         vld[wr_addr] <= wr_data[ENT_W-1];
   end

   // Registered read; a same-edge write is not seen (old contents returned).
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_rw    <= 1'b0;
         rd_frame <= '0;
      end else if (rd_en) begin
         rd_valid <= vld[rd_addr];
         rd_rw    <= store[rd_addr][FRAME_W];
         rd_frame <= store[rd_addr][FRAME_W-1:0];
      end
   end

endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
   import xlate_pkg::*;
#(
   parameter int SEG_W   = 4,
   parameter int PAGE_W  = 16,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 20,
   parameter int PT_AW   = 8,
   localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
   localparam int PA_W   = FRAME_W + OFF_W,
   localparam int SEG_EW = PT_AW + PAGE_W + 1,
   localparam int PTE_EW = FRAME_W + 2,
   localparam int TW     = (SEG_EW > PTE_EW) ? SEG_EW : PTE_EW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [2:0]       rsp_fault,
   input  logic             tbl_wr_en,
   input  logic             tbl_wr_page,
   input  logic [PT_AW-1:0] tbl_wr_addr,
   input  logic [TW-1:0]    tbl_wr_data
);

   initial begin
      assert (SEG_W >= 1 && PAGE_W >= 1 && OFF_W >= 1 && FRAME_W >= 1)
         else $error("field widths must be positive");
      assert (PT_AW >= SEG_W && PT_AW <= 12)
         else $error("page memory index must cover segment index and stay small");
   end

   logic [SEG_W-1:0]  va_seg;
   logic [PAGE_W-1:0] va_page;
   logic [OFF_W-1:0]  va_off;
   assign {va_seg, va_page, va_off} = req_vaddr;

   logic [PT_AW-1:0]  sg_base;
   logic [PAGE_W-1:0] sg_len;
   logic              sg_rw;

   seg_table #(.SEG_W(SEG_W), .PAGE_W(PAGE_W), .PT_AW(PT_AW)) i_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en && !tbl_wr_page),
      .wr_idx  (tbl_wr_addr[SEG_W-1:0]),
      .wr_data (tbl_wr_data[SEG_EW-1:0]),
      .rd_idx  (va_seg),
      .rd_base (sg_base),
      .rd_len  (sg_len),
      .rd_rw   (sg_rw)
   );

   // Page index into the page-table memory, modulo its depth.
   logic [PT_AW-1:0] page_lo;
   if (PAGE_W >= PT_AW) begin : g_pg_trunc
      assign page_lo = va_page[PT_AW-1:0];
   end else begin : g_pg_ext
      assign page_lo = {{(PT_AW-PAGE_W){1'b0}}, va_page};
   end
   logic [PT_AW-1:0] pt_idx;
   assign pt_idx = sg_base + page_lo;

   logic adv;
   assign adv       = !rsp_valid || rsp_ready;
   assign req_ready = adv;

   logic               pm_valid, pm_rw;
   logic [FRAME_W-1:0] pm_frame;

   page_mem #(.PT_AW(PT_AW), .FRAME_W(FRAME_W)) i_pm (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr_en && tbl_wr_page),
      .wr_addr  (tbl_wr_addr),
      .wr_data  (tbl_wr_data[PTE_EW-1:0]),
      .rd_en    (adv),
      .rd_addr  (pt_idx),
      .rd_frame (pm_frame),
      .rd_rw    (pm_rw),
      .rd_valid (pm_valid)
   );

   // Stage 1: segment-level checks, aligned with the page-memory read.
   logic             s1_valid, s1_write, s1_bound, s1_seg_ro;
   logic [OFF_W-1:0] s1_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_write  <= 1'b0;
         s1_bound  <= 1'b0;
         s1_seg_ro <= 1'b0;
         s1_off    <= '0;
      end else if (adv) begin
         s1_valid  <= req_valid;
         s1_write  <= req_write;
         s1_bound  <= (va_page >= sg_len);
         s1_seg_ro <= req_write && !sg_rw;
         s1_off    <= va_off;
      end
   end

   // Stage 2: page-level checks and result register.
   fault_e s2_fault;
   assign s2_fault = pick_fault(s1_bound, s1_seg_ro, !pm_valid, s1_write && !pm_rw);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 3'd0;
         rsp_paddr <= '0;
      end else if (adv) begin
         rsp_valid <= s1_valid;
         rsp_fault <= s2_fault;
         rsp_paddr <= (s2_fault == FLT_NONE) ? {pm_frame, s1_off} : '0;
      end
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

   assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault <= 3'd4);

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) ##1 req_ready |=> rsp_valid);

   assert_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(s1_valid));

endmodule

// File: tb/test_seg_page_xlate.sv
module test_seg_page_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
   logic [31:0] req_vaddr = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_fault;
   logic        tbl_wr_en = 1'b0, tbl_wr_page = 1'b0;
   logic [7:0]  tbl_wr_addr = '0;
   logic [24:0] tbl_wr_data = '0;

   seg_page_xlate i_seg_page_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_page(tbl_wr_page), .tbl_wr_addr(tbl_wr_addr),
      .tbl_wr_data(tbl_wr_data)
   );

   always #4 clk = ~clk;   // 125 MHz

   int compared = 0, mismatched = 0, cyc = 0;
   bit stall_mode = 1'b0;
   string tag_override = "";

   // Behavioural model state.
   int sbase [16];
   int slen  [16];
   bit srw   [16];
   int pfrm  [256];
   bit pwr   [256];
   bit pvld  [256];

   typedef struct { logic [31:0] pa; logic [2:0] f; int acc; bit lat; bit seen; string tag; } exp_t;
   exp_t q[$];

   initial begin
      for (int i = 0; i < 16; i++) begin sbase[i] = 0; slen[i] = 0; srw[i] = 0; end
      for (int i = 0; i < 256; i++) begin pfrm[i] = 0; pwr[i] = 0; pvld[i] = 0; end
   end

   function automatic string ftag(input logic [2:0] f);
      case (f)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic model(input logic [31:0] va, input logic wr,
                        output logic [31:0] pa, output logic [2:0] f);
      int s, pg, idx;
      s = int'(va[31:28]); pg = int'(va[27:12]);
      idx = (sbase[s] + pg) % 256;
      if (pg >= slen[s])           f = 3'd1;
      else if (wr && !srw[s])      f = 3'd2;
      else if (!pvld[idx])         f = 3'd3;
      else if (wr && !pwr[idx])    f = 3'd4;
      else                         f = 3'd0;
      pa = (f == 3'd0) ? {pfrm[idx][19:0], va[11:0]} : 32'd0;
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   bit prev_hold = 1'b0;
   logic [31:0] prev_pa;
   logic [2:0]  prev_f;

   // Per-cycle comparison, mid-cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R9", "unexpected response", {29'd0, rsp_fault}, 32'd0);
            end else begin
               if (!q[0].seen) begin
                  q[0].seen = 1'b1;
                  if (q[0].lat)
                     check(cyc == q[0].acc + 2, "R9", "latency", cyc, q[0].acc + 2);
               end
               check(rsp_fault == q[0].f, (q[0].tag != "") ? q[0].tag : ftag(q[0].f),
                     "fault", {29'd0, rsp_fault}, {29'd0, q[0].f});
               check(rsp_paddr == q[0].pa,
                     (q[0].tag != "") ? q[0].tag : ((q[0].f != 0) ? "R8" : "R2"),
                     "paddr", rsp_paddr, q[0].pa);
               if (prev_hold)
                  check(rsp_paddr == prev_pa && rsp_fault == prev_f, "R10", "held response",
                        rsp_paddr, prev_pa);
               if (!rsp_ready)
                  check(!req_ready, "R10", "req_ready during stall", {31'd0, req_ready}, 32'd0);
               if (rsp_ready) void'(q.pop_front());
            end
         end
         prev_hold = rsp_valid && !rsp_ready;
         prev_pa = rsp_paddr; prev_f = rsp_fault;
         // Acceptance at the coming edge uses the table contents before this cycle's write.
         if (req_valid && req_ready) begin
            exp_t e;
            model(req_vaddr, req_write, e.pa, e.f);
            e.acc = cyc; e.lat = !stall_mode; e.seen = 1'b0; e.tag = tag_override;
            q.push_back(e);
         end
         if (tbl_wr_en) begin
            if (!tbl_wr_page) begin
               sbase[tbl_wr_addr[3:0]] = int'(tbl_wr_data[7:0]);
               slen[tbl_wr_addr[3:0]]  = int'(tbl_wr_data[23:8]);
               srw[tbl_wr_addr[3:0]]   = tbl_wr_data[24];
            end else begin
               pfrm[tbl_wr_addr] = int'(tbl_wr_data[19:0]);
               pwr[tbl_wr_addr]  = tbl_wr_data[20];
               pvld[tbl_wr_addr] = tbl_wr_data[21];
            end
         end
      end
   end

   // Consumer readiness.
   initial begin
      forever begin
         @(posedge clk); #1;
         rsp_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
      end
   end

   task automatic send(input logic [3:0] s, input logic [15:0] pg, input logic [11:0] off,
                       input logic wr);
      req_valid = 1'b1; req_vaddr = {s, pg, off}; req_write = wr;
      forever begin
         @(negedge clk);
         if (req_ready) begin @(posedge clk); #1; break; end
         @(posedge clk); #1;
      end
      req_valid = 1'b0;
   endtask

   task automatic twrite(input logic pg, input logic [7:0] a, input logic [24:0] d);
      tbl_wr_en = 1'b1; tbl_wr_page = pg; tbl_wr_addr = a; tbl_wr_data = d;
      @(posedge clk); #1;
      tbl_wr_en = 1'b0;
   endtask

   function automatic logic [24:0] segw(input int base, input int len, input bit rw);
      return {rw, len[15:0], base[7:0]};
   endfunction

   function automatic logic [24:0] ptew(input int frame, input bit rw, input bit v);
      return {3'd0, v, rw, frame[19:0]};
   endfunction

   task automatic drain();
      while (q.size() != 0) begin @(posedge clk); #1; end
      stall_mode = 1'b0;
      repeat (2) begin @(posedge clk); #1; end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      check(!rsp_valid, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      check(req_ready, "R1", "req_ready after reset", {31'd0, req_ready}, 32'd1);
      @(posedge clk); #1;
      tag_override = "R1";
      send(4'd5, 16'd0, 12'h123, 1'b0);   // empty segment table: bound fault
      tag_override = "";
      drain();

      // R11: load tables
      twrite(1'b0, 8'd1, segw(8'h10, 4, 1'b1));
      twrite(1'b0, 8'd2, segw(8'hFE, 32, 1'b0));
      twrite(1'b0, 8'd3, segw(8'h40, 1, 1'b1));
      twrite(1'b1, 8'h10, ptew(20'hABCDE, 1'b1, 1'b1));
      twrite(1'b1, 8'h11, ptew(20'h12345, 1'b0, 1'b1));
      twrite(1'b1, 8'h12, ptew(20'hFFFFF, 1'b1, 1'b0));
      twrite(1'b1, 8'h13, ptew(20'h00001, 1'b1, 1'b1));
      twrite(1'b1, 8'hFE, ptew(20'h55555, 1'b1, 1'b1));
      twrite(1'b1, 8'h00, ptew(20'h77777, 1'b1, 1'b1));
      repeat (2) begin @(posedge clk); #1; end

      // Back-to-back directed cases, rsp_ready high (R9 latency checked)
      send(4'd1, 16'd0, 12'hABC, 1'b0);     // R2 success read
      send(4'd1, 16'd0, 12'h001, 1'b1);     // R2 success write
      send(4'd1, 16'd1, 12'h777, 1'b1);     // R6 page read-only write
      send(4'd1, 16'd1, 12'h777, 1'b0);     // R6 read allowed
      send(4'd1, 16'd2, 12'h000, 1'b0);     // R5 invalid entry
      send(4'd1, 16'd3, 12'hFFF, 1'b1);     // R2 last page in segment
      send(4'd1, 16'd4, 12'h000, 1'b0);     // R3 page == size
      send(4'd1, 16'hFFFF, 12'h000, 1'b0);  // R3 far out
      send(4'd2, 16'd0, 12'h010, 1'b0);     // R4 read through read-only segment allowed
      send(4'd2, 16'd0, 12'h010, 1'b1);     // R4 write refused
      send(4'd2, 16'd2, 12'h321, 1'b0);     // R11 index wraps to 0x00
      send(4'd2, 16'd32, 12'h000, 1'b1);    // R7 bound beats segment permission
      send(4'd2, 16'd1, 12'h000, 1'b1);     // R7 segment permission beats invalid entry
      send(4'd3, 16'd0, 12'h000, 1'b0);     // R5 never-written entry
      send(4'd0, 16'd0, 12'h000, 1'b0);     // R3 size-zero segment
      drain();

      // R11: same-cycle write and request sees old entry, next sees new
      tag_override = "R11";
      tbl_wr_en = 1'b1; tbl_wr_page = 1'b1; tbl_wr_addr = 8'h10;
      tbl_wr_data = ptew(20'h11111, 1'b1, 1'b1);
      send(4'd1, 16'd0, 12'h042, 1'b0);
      tbl_wr_en = 1'b0;
      send(4'd1, 16'd0, 12'h043, 1'b0);
      tbl_wr_en = 1'b1; tbl_wr_page = 1'b0; tbl_wr_addr = 8'd1;
      tbl_wr_data = segw(8'h10, 4, 1'b0);
      send(4'd1, 16'd0, 12'h044, 1'b1);     // old segment: write allowed
      tbl_wr_en = 1'b0;
      send(4'd1, 16'd0, 12'h045, 1'b1);     // new segment: read-only
      tag_override = "";
      drain();

      // R10: random traffic under backpressure
      stall_mode = 1'b1;
      for (int i = 0; i < 300; i++)
         send(4'($urandom_range(0, 3)), 16'($urandom_range(0, 5)), 12'($urandom),
              1'($urandom_range(0, 1)));
      drain();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #800000;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule